// File: doc/BRIEF.md
# Flash Program/Erase Setup Register Block

This block holds the control state that prepares on-chip flash for a program or erase operation. It sits on a simple byte-wide register bus. A control register carries a sticky error flag and two setup bits, one for erase and one for program. A bank of erase-block select registers names the single flash block that an erase will target. Side inputs carry the software write-enable level, the current power mode, a hardware-standby condition and an error-detect pulse. The block applies the gating, clearing and single-selection rules to every update.

Software sets the matching setup bit before it asks for an erase or program pulse. The block passes the erase-enable or program-enable request through to its output only while the matching setup bit is 1. The flash array and the pulse timing live elsewhere.

Top module: `fpe_regs`

## Requirements
- R1: After an active-low reset, or on any clock edge where `hw_standby` is 1, every register reads 0x00, `err_flag` is 0, `blk_sel` is 0 and both enable outputs are 0.
- R2: Address 0 is the control register. It reads bit 7 = error flag, bit 1 = erase setup, bit 0 = program setup, and bits 6..2 = 0. Bus writes to bits 7..2 have no effect. Address 3 is unmapped and reads 0x00.
- R3: A control write takes bit 1 into erase setup and bit 0 into program setup, visible on the next cycle. A setup bit can only become 1 while `swe` is 1. Writing 0 cancels it.
- R4: Both setup bits are forced to 0, overriding any write, on every edge where `swe` is 0 or `pmode` is software standby (2), sub-active (3), sub-sleep (4) or watch (5). Active (0) and sleep (1) leave them alone.
- R5: Address 1 holds erase blocks 7..0 and address 2 holds blocks 15..8. `blk_sel` = {addr 2, addr 1}. Both registers are cleared when `swe` is 0 or `pmode` is 2, 3 or 4. Watch (5) and sleep (1) keep them.
- R6: An erase-block write is merged with the other register's current contents. If the 16-bit result has more than one bit set, both registers become 0x00. Otherwise the merged value is stored.
- R7: An `err_detect` pulse sets the error flag on the next edge. The flag stays set through writes, `swe` changes and power modes, and only reset or `hw_standby` clears it.
- R8: `erase_en` (or `prog_en`) is 1 in the cycle after an edge where `erase_req` (or `prog_req`) was 1 and erase setup (or program setup) was 1. A request made while the setup bit is 0 leaves the output at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| hw_standby | input | 1 | Hardware standby; clears all state synchronously |
| swe | input | 1 | Software write-enable level |
| pmode | input | 3 | Power mode code (0 active, 1 sleep, 2 sw standby, 3 sub-active, 4 sub-sleep, 5 watch) |
| err_detect | input | 1 | Error-detect pulse |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| erase_req | input | 1 | Request to raise erase enable |
| prog_req | input | 1 | Request to raise program enable |
| erase_setup | output | 1 | Erase setup state |
| prog_setup | output | 1 | Program setup state |
| err_flag | output | 1 | Sticky error flag |
| blk_sel | output | NUM_BLK_REGS*DATA_W | Selected erase block, at most one bit set |
| erase_en | output | 1 | Gated erase enable |
| prog_en | output | 1 | Gated program enable |

## Verification
The bench targets a few corner cases:
- Two selections that sit in different erase-block registers. A design that checked only the written byte would keep both bits and select two blocks.
- Watch mode. A design that shared one clear term would either wipe the block selection or keep the setup bits in watch.
- Writes to the error and reserved bit positions, and requests made while setup is 0. A wrong design would leak a written 1 into a read, or raise an enable without setup.
- The error flag across power-mode clears. A design that lost it there would fail.

// File: rtl/fpe_pkg.sv
package fpe_pkg;

   typedef enum logic [2:0] {
      PM_ACTIVE   = 3'd0,
      PM_SLEEP    = 3'd1,
      PM_SW_STBY  = 3'd2,
      PM_SUB_ACT  = 3'd3,
      PM_SUB_SLP  = 3'd4,
      PM_WATCH    = 3'd5
   } pmode_e;

   localparam int ERR_POS = 7;
   localparam int ESU_POS = 1;
   localparam int PSU_POS = 0;

   // Setup bits drop in every low-power mode, watch included.
   function automatic logic setup_clear_mode(input logic [2:0] pm);
      return (pm == PM_SW_STBY) || (pm == PM_SUB_ACT) ||
             (pm == PM_SUB_SLP) || (pm == PM_WATCH);
   endfunction

   // Block selection survives watch mode.
   function automatic logic blk_clear_mode(input logic [2:0] pm);
      return (pm == PM_SW_STBY) || (pm == PM_SUB_ACT) || (pm == PM_SUB_SLP);
   endfunction

endpackage

// File: rtl/fpe_ctrl_reg.sv
module fpe_ctrl_reg #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hw_stby,
   input  logic              setup_clr,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              err_pulse,
   output logic              esu,
   output logic              psu,
   output logic              err,
   output logic [DATA_W-1:0] rd_val
);
   import fpe_pkg::*;

   logic esu_q, psu_q, err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         esu_q <= 1'b0;
         psu_q <= 1'b0;
         err_q <= 1'b0;
      end else if (hw_stby) begin
         esu_q <= 1'b0;
         psu_q <= 1'b0;
         err_q <= 1'b0;
      end else begin
         if (err_pulse) err_q <= 1'b1;
         if (setup_clr) begin
            esu_q <= 1'b0;
            psu_q <= 1'b0;
         end else if (wr) begin
            esu_q <= wdata[ESU_POS];
            psu_q <= wdata[PSU_POS];
         end
      end
   end

   always_comb begin
      rd_val          = '0;
      rd_val[ERR_POS] = err_q;
      rd_val[ESU_POS] = esu_q;
      rd_val[PSU_POS] = psu_q;
   end

   assign esu = esu_q;
   assign psu = psu_q;
   assign err = err_q;

endmodule

// File: rtl/fpe_blk_sel.sv
module fpe_blk_sel #(
   parameter int DATA_W           = 8,
   parameter int NUM_REGS         = 2,
   parameter bit MULTI_CLEARS_ALL = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       hw_stby,
   input  logic                       clr,
   input  logic [NUM_REGS-1:0]        wr_sel,
   input  logic [DATA_W-1:0]          wdata,
   output logic [NUM_REGS*DATA_W-1:0] sel
);
   localparam int TOT_W = NUM_REGS * DATA_W;

   logic [TOT_W-1:0] q;
   logic [TOT_W-1:0] merged;
   logic [TOT_W-1:0] on_multi;
   logic             any_wr;
   logic             multi;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_merge
      assign merged[i*DATA_W +: DATA_W] = wr_sel[i] ? wdata : q[i*DATA_W +: DATA_W];
   end

   assign any_wr = |wr_sel;
   assign multi  = $countones(merged) > 1;

   if (MULTI_CLEARS_ALL) begin : g_clear_all
      assign on_multi = '0;
   end else begin : g_reject
      assign on_multi = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             q <= '0;
      else if (hw_stby || clr) q <= '0;
      else if (any_wr)        q <= multi ? on_multi : merged;
   end

   assign sel = q;

endmodule

// File: rtl/fpe_enable_gate.sv
module fpe_enable_gate #(
   parameter int LANES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hw_stby,
   input  logic [LANES-1:0] req,
   input  logic [LANES-1:0] setup,
   output logic [LANES-1:0] en
);
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic en_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       en_q <= 1'b0;
         else if (hw_stby) en_q <= 1'b0;
         else              en_q <= req[i] & setup[i];
      end
      assign en[i] = en_q;
   end

endmodule

// File: rtl/fpe_addr_dec.sv
module fpe_addr_dec #(
   parameter int ADDR_W        = 2,
   parameter int DATA_W        = 8,
   parameter int NUM_BLK_REGS  = 2,
   parameter int CTRL_ADDR     = 0,
   parameter int BLK_BASE_ADDR = 1
) (
   input  logic [ADDR_W-1:0]              addr,
   input  logic                           wr,
   input  logic [DATA_W-1:0]              ctrl_rd,
   input  logic [NUM_BLK_REGS*DATA_W-1:0] blk_q,
   output logic                           ctrl_wr,
   output logic [NUM_BLK_REGS-1:0]        blk_wr,
   output logic [DATA_W-1:0]              rdata
);
   localparam logic [ADDR_W-1:0] CA = ADDR_W'(CTRL_ADDR);

   logic                    ctrl_hit;
   logic [NUM_BLK_REGS-1:0] blk_hit;

   assign ctrl_hit = (addr == CA);
   assign ctrl_wr  = wr & ctrl_hit;

   for (genvar i = 0; i < NUM_BLK_REGS; i++) begin : g_blk
      localparam logic [ADDR_W-1:0] BA = ADDR_W'(BLK_BASE_ADDR + i);
      assign blk_hit[i] = (addr == BA);
      assign blk_wr[i]  = wr & blk_hit[i];
   end

   always_comb begin
      rdata = '0;
      if (ctrl_hit) rdata = ctrl_rd;
      for (int i = 0; i < NUM_BLK_REGS; i++) begin
         if (blk_hit[i]) rdata = blk_q[i*DATA_W +: DATA_W];
      end
   end

endmodule

// File: rtl/fpe_regs.sv
module fpe_regs #(
   parameter int ADDR_W        = 2,
   parameter int DATA_W        = 8,
   parameter int NUM_BLK_REGS  = 2,
   parameter int CTRL_ADDR     = 0,
   parameter int BLK_BASE_ADDR = 1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           hw_standby,
   input  logic                           swe,
   input  logic [2:0]                     pmode,
   input  logic                           err_detect,
   input  logic [ADDR_W-1:0]              bus_addr,
   input  logic                           bus_wr,
   input  logic [DATA_W-1:0]              bus_wdata,
   output logic [DATA_W-1:0]              bus_rdata,
   input  logic                           erase_req,
   input  logic                           prog_req,
   output logic                           erase_setup,
   output logic                           prog_setup,
   output logic                           err_flag,
   output logic [NUM_BLK_REGS*DATA_W-1:0] blk_sel,
   output logic                           erase_en,
   output logic                           prog_en
);
   import fpe_pkg::*;

   if (DATA_W < 8) begin : g_bad_width
      $fatal(1, "fpe_regs: DATA_W must be at least 8");
   end
   if (NUM_BLK_REGS < 1) begin : g_bad_count
      $fatal(1, "fpe_regs: NUM_BLK_REGS must be at least 1");
   end
   if (BLK_BASE_ADDR + NUM_BLK_REGS > (1 << ADDR_W)) begin : g_bad_map
      $fatal(1, "fpe_regs: block registers exceed address space");
   end
   if (CTRL_ADDR >= BLK_BASE_ADDR && CTRL_ADDR < BLK_BASE_ADDR + NUM_BLK_REGS) begin : g_overlap
      $fatal(1, "fpe_regs: control address overlaps block registers");
   end

   logic                           ctrl_wr;
   logic [NUM_BLK_REGS-1:0]        blk_wr;
   logic [DATA_W-1:0]              ctrl_rd;
   logic [NUM_BLK_REGS*DATA_W-1:0] blk_q;
   logic                           setup_clr;
   logic                           blk_clr;
   logic                           esu, psu;
   logic [1:0]                     en;

   assign setup_clr = !swe || setup_clear_mode(pmode);
   assign blk_clr   = !swe || blk_clear_mode(pmode);

   fpe_addr_dec #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_BLK_REGS(NUM_BLK_REGS),
      .CTRL_ADDR(CTRL_ADDR), .BLK_BASE_ADDR(BLK_BASE_ADDR)
   ) u_dec (
      .addr(bus_addr), .wr(bus_wr), .ctrl_rd(ctrl_rd), .blk_q(blk_q),
      .ctrl_wr(ctrl_wr), .blk_wr(blk_wr), .rdata(bus_rdata)
   );

   fpe_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .hw_stby(hw_standby), .setup_clr(setup_clr),
      .wr(ctrl_wr), .wdata(bus_wdata), .err_pulse(err_detect),
      .esu(esu), .psu(psu), .err(err_flag), .rd_val(ctrl_rd)
   );

   fpe_blk_sel #(.DATA_W(DATA_W), .NUM_REGS(NUM_BLK_REGS), .MULTI_CLEARS_ALL(1'b1)) u_blk (
      .clk(clk), .rst_n(rst_n), .hw_stby(hw_standby), .clr(blk_clr),
      .wr_sel(blk_wr), .wdata(bus_wdata), .sel(blk_q)
   );

   fpe_enable_gate #(.LANES(2)) u_gate (
      .clk(clk), .rst_n(rst_n), .hw_stby(hw_standby),
      .req({prog_req, erase_req}), .setup({psu, esu}), .en(en)
   );

   assign erase_setup = esu;
   assign prog_setup  = psu;
   assign blk_sel     = blk_q;
   assign erase_en    = en[0];
   assign prog_en     = en[1];

endmodule

// File: rtl/fpe_regs_chk.sv
module fpe_regs_chk #(
   parameter int ADDR_W = 2,
   parameter int DATA_W = 8,
   parameter int BLK_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hw_standby,
   input logic              swe,
   input logic [2:0]        pmode,
   input logic              err_detect,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              erase_setup,
   input logic              prog_setup,
   input logic              err_flag,
   input logic [BLK_W-1:0]  blk_sel,
   input logic              erase_en,
   input logic              prog_en
);
   logic lp_setup, lp_blk;
   assign lp_setup = (pmode >= 3'd2) && (pmode <= 3'd5);
   assign lp_blk   = (pmode >= 3'd2) && (pmode <= 3'd4);

   p_hw_standby_r1: assert property (@(posedge clk) disable iff (!rst_n)
      hw_standby |=> (!err_flag && !erase_setup && !prog_setup && blk_sel == '0 && !erase_en && !prog_en));

   p_rsv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == '0) |-> (bus_rdata[6:2] == '0));

   p_setup_needs_swe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_setup || prog_setup) |-> $past(swe));

   p_lowpwr_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (lp_setup || !swe) |=> (!erase_setup && !prog_setup));

   p_lowpwr_blk_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (lp_blk || !swe) |=> (blk_sel == '0));

   p_blk_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(blk_sel));

   p_err_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (err_detect && !hw_standby) |=> err_flag);

   p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (err_flag && !hw_standby) |=> err_flag);

   p_erase_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      erase_en |-> $past(erase_setup));

   p_prog_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      prog_en |-> $past(prog_setup));

endmodule

bind fpe_regs fpe_regs_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(NUM_BLK_REGS*DATA_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .hw_standby(hw_standby), .swe(swe), .pmode(pmode),
   .err_detect(err_detect), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
   .erase_setup(erase_setup), .prog_setup(prog_setup), .err_flag(err_flag),
   .blk_sel(blk_sel), .erase_en(erase_en), .prog_en(prog_en)
);

// File: tb/fpe_regs_test.sv
`timescale 1ns/1ps
module fpe_regs_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hw_standby = 1'b0;
   logic        swe = 1'b0;
   logic [2:0]  pmode = 3'd0;
   logic        err_detect = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_wdata = 8'd0;
   logic [7:0]  bus_rdata;
   logic        erase_req = 1'b0;
   logic        prog_req = 1'b0;
   logic        erase_setup, prog_setup, err_flag, erase_en, prog_en;
   logic [15:0] blk_sel;

   always #10 clk = ~clk;

   fpe_regs uut (
      .clk(clk), .rst_n(rst_n), .hw_standby(hw_standby), .swe(swe), .pmode(pmode),
      .err_detect(err_detect), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .erase_req(erase_req),
      .prog_req(prog_req), .erase_setup(erase_setup), .prog_setup(prog_setup),
      .err_flag(err_flag), .blk_sel(blk_sel), .erase_en(erase_en), .prog_en(prog_en)
   );

   typedef enum int {S_RD, S_BLK, S_ERR, S_EEN, S_PEN} sel_e;
   typedef struct {
      sel_e        sel;
      logic [15:0] exp;
      string       tag;
   } item_t;

   item_t q[$];
   int    n_run  = 0;
   int    n_fail = 0;
   bit    done   = 1'b0;

   // Monitor: compares queued expectations against the ports at the falling edge.
   always @(negedge clk) begin
      while (q.size() > 0) begin
         item_t it;
         logic [15:0] act;
         it = q.pop_front();
         case (it.sel)
            S_RD:    act = {8'd0, bus_rdata};
            S_BLK:   act = blk_sel;
            S_ERR:   act = {15'd0, err_flag};
            S_EEN:   act = {15'd0, erase_en};
            default: act = {15'd0, prog_en};
         endcase
         n_run++;
         if (act !== it.exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", it.tag, act, it.exp);
         end
      end
   end

   task automatic tick();
      @(posedge clk); #2;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      tick();
      bus_wr = 1'b0;
   endtask

   task automatic push(input sel_e s, input logic [15:0] e, input string tag);
      q.push_back('{s, e, tag});
      @(negedge clk); #1;
   endtask

   task automatic exp_rd(input logic [1:0] a, input logic [7:0] d, input string tag);
      bus_addr = a; #1;
      push(S_RD, {8'd0, d}, tag);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      exp_rd(2'd0, 8'h00, "R1 ctrl after reset");
      exp_rd(2'd1, 8'h00, "R1 blk lo after reset");
      exp_rd(2'd2, 8'h00, "R1 blk hi after reset");
      push(S_ERR, 16'd0, "R1 err after reset");

      // R3 no setup without swe
      wr(2'd0, 8'h03);
      exp_rd(2'd0, 8'h00, "R3 setup blocked while swe=0");
      swe = 1'b1;
      // R2 reserved and error bits not writable
      wr(2'd0, 8'hFE);
      exp_rd(2'd0, 8'h02, "R2 reserved/err bits discarded");
      wr(2'd0, 8'h01);
      exp_rd(2'd0, 8'h01, "R3 program setup only");
      wr(2'd0, 8'h00);
      exp_rd(2'd0, 8'h00, "R3 writing 0 cancels");
      exp_rd(2'd3, 8'h00, "R2 unmapped address");

      // R8 enable gating
      wr(2'd0, 8'h03);
      erase_req = 1'b1; prog_req = 1'b1;
      tick();
      push(S_EEN, 16'd1, "R8 erase_en with setup");
      push(S_PEN, 16'd1, "R8 prog_en with setup");
      erase_req = 1'b0; prog_req = 1'b0;
      tick();
      push(S_EEN, 16'd0, "R8 erase_en drops with request");
      wr(2'd0, 8'h02);
      erase_req = 1'b0; prog_req = 1'b1;
      tick(); tick();
      push(S_PEN, 16'd0, "R8 prog_en ignored without setup");
      prog_req = 1'b0;
      wr(2'd0, 8'h00);
      erase_req = 1'b1;
      tick(); tick();
      push(S_EEN, 16'd0, "R8 erase_en ignored without setup");
      erase_req = 1'b0;

      // R4 power-mode and swe clears
      wr(2'd0, 8'h03);
      pmode = 3'd5;
      tick();
      exp_rd(2'd0, 8'h00, "R4 watch clears setup");
      wr(2'd0, 8'h03);
      exp_rd(2'd0, 8'h00, "R4 write overridden in watch");
      pmode = 3'd1;
      wr(2'd0, 8'h03);
      exp_rd(2'd0, 8'h03, "R4 sleep keeps setup");
      pmode = 3'd0;
      swe = 1'b0;
      tick();
      swe = 1'b1;
      exp_rd(2'd0, 8'h00, "R4 swe low clears setup");

      // R5 / R6 erase-block selection
      wr(2'd1, 8'h04);
      push(S_BLK, 16'h0004, "R5 single block low");
      exp_rd(2'd1, 8'h04, "R5 read block low");
      wr(2'd2, 8'h10);
      push(S_BLK, 16'h0000, "R6 cross-register double select clears");
      wr(2'd2, 8'h80);
      push(S_BLK, 16'h8000, "R5 single block high");
      wr(2'd1, 8'h03);
      push(S_BLK, 16'h0000, "R6 in-byte double select clears");
      wr(2'd1, 8'h20);
      pmode = 3'd5;
      tick();
      push(S_BLK, 16'h0020, "R5 watch keeps blocks");
      pmode = 3'd1;
      tick();
      push(S_BLK, 16'h0020, "R5 sleep keeps blocks");
      pmode = 3'd2;
      tick();
      push(S_BLK, 16'h0000, "R5 sw standby clears blocks");
      pmode = 3'd0;
      wr(2'd1, 8'h01);
      pmode = 3'd3;
      tick();
      push(S_BLK, 16'h0000, "R5 sub-active clears blocks");
      pmode = 3'd0;
      wr(2'd2, 8'h02);
      pmode = 3'd4;
      tick();
      push(S_BLK, 16'h0000, "R5 sub-sleep clears blocks");
      pmode = 3'd0;
      wr(2'd1, 8'h08);
      swe = 1'b0;
      tick();
      swe = 1'b1;
      push(S_BLK, 16'h0000, "R5 swe low clears blocks");

      // R7 sticky error flag
      err_detect = 1'b1;
      tick();
      err_detect = 1'b0;
      push(S_ERR, 16'd1, "R7 error pulse sets flag");
      wr(2'd0, 8'h00);
      exp_rd(2'd0, 8'h80, "R7 write cannot clear flag");
      wr(2'd0, 8'h82);
      exp_rd(2'd0, 8'h82, "R7 flag with erase setup");
      pmode = 3'd2;
      tick();
      pmode = 3'd0;
      exp_rd(2'd0, 8'h80, "R7 flag survives power mode");

      // R1 hardware standby
      wr(2'd1, 8'h40);
      wr(2'd0, 8'h01);
      hw_standby = 1'b1;
      tick();
      hw_standby = 1'b0;
      exp_rd(2'd0, 8'h00, "R1 hw standby clears ctrl");
      push(S_BLK, 16'h0000, "R1 hw standby clears blocks");
      push(S_ERR, 16'd0, "R1 hw standby clears error");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule